// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block produces the clock driven to a smart card contact from a faster reference clock. It offers four rates, the base rate and that rate divided by two, four and eight. Two select pins choose the rate through a Gray-style code. A run input from the activation sequencer starts and stops the card clock. The output is a register clocked by the reference clock. Its levels are counted in reference cycles. The base unit is `UNIT_CYC` cycles per level, and each slower rate multiplies that length.

A new rate is taken only when the output finishes a low level. The period in progress therefore always completes at its old width, and the next high level starts at the full width of the new rate. Removing the run input lets the current high and low levels finish, then holds the output low with the level counter frozen. The selects and the run input come from another clock domain, so each passes through `SYNC_STAGES` flops before use.

Top module: `card_clk_divider`

## Requirements
- R1: While `rst_i` is high, `card_clk_o` is low. After reset is released it stays low for exactly `UNIT_CYC` cycles before the first high level, provided `run_i` was already high during reset.
- R2: The select code {`rate_a_i`,`rate_b_i`} sets the length L of every high and every low level. 2'b00 gives L = 8·`UNIT_CYC`, 2'b01 gives 4·`UNIT_CYC`, 2'b11 gives 2·`UNIT_CYC` and 2'b10 gives `UNIT_CYC` reference cycles.
- R3: A select change is applied only at the end of a low level. The high and low levels in progress keep their old length, and the next high level has the full length of the new code.
- R4: No level of `card_clk_o` is shorter than `UNIT_CYC` cycles. A low level is never shorter than the high level before it.
- R5: When `run_i` falls, the current high level and the low level after it run to full length. After that the output stays low for as long as `run_i` stays low.
- R6: When the output is stopped and has been low for at least one full level, a rise of `run_i` makes `card_clk_o` high after `SYNC_STAGES`+1 cycles. That first high level has the full length of the selected rate.
- R7: A completed high level lasts one of the four lengths from R2.
- R8: The two select inputs never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rate_a_i | input | 1 | Rate select, first bit of the code |
| rate_b_i | input | 1 | Rate select, second bit of the code |
| run_i | input | 1 | Card clock enable from the sequencer |
| card_clk_o | output | 1 | Registered divided card clock |

## Verification
The checker assumes that the select pins follow a one-bit-at-a-time rule (R8). It also assumes that the run input is free to toggle at any point in a level. The stimulus moves through a select sequence in which neighbouring codes differ in one bit only, including the wrap from the base rate back to the slowest. All inputs change at falling reference edges, so the synchronizers always capture a stable value. The run input is dropped during a high level and raised again only once the output has sat low for longer than the slowest level, which is the settled condition R6 speaks of.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef logic [1:0] rate_shift_t;

  // Gray-ordered select code to a power-of-two multiplier exponent.
  function automatic rate_shift_t decode_rate(input logic sel_a, input logic sel_b);
    rate_shift_t sh;
    unique case ({sel_a, sel_b})
      2'b00:   sh = 2'd3;
      2'b01:   sh = 2'd2;
      2'b11:   sh = 2'd1;
      default: sh = 2'd0;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[s] <= '0;
        else       stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[s] <= '0;
        else       stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clkdiv_level_timer.sv
module clkdiv_level_timer #(
  parameter int CNT_W    = 6,
  parameter int RST_SPAN = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  // Counts down to zero and then holds; a load restarts a level.
  always_ff @(posedge clk_i) begin
    if (rst_i)                cnt_q <= CNT_W'(RST_SPAN - 1);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_phase_ctrl.sv
module clkdiv_phase_ctrl
  import clkdiv_pkg::*;
#(
  parameter int UNIT_CYC = 8,
  parameter int CNT_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             expired_i,
  input  logic             run_s_i,
  input  rate_shift_t      shift_s_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             phase_o
);

  logic        phase_q, phase_d;
  logic        active_q, active_d;
  rate_shift_t shift_q, shift_d;

  function automatic logic [CNT_W-1:0] span_m1(input rate_shift_t sh);
    return CNT_W'((UNIT_CYC << sh) - 1);
  endfunction

  always_comb begin
    phase_d    = phase_q;
    active_d   = active_q;
    shift_d    = shift_q;
    load_o     = 1'b0;
    load_val_o = span_m1(shift_q);
    if (expired_i) begin
      if (active_q && phase_q) begin
        // High level done: low level of the same rate.
        phase_d = 1'b0;
        load_o  = 1'b1;
      end else if (run_s_i) begin
        // Low level done (or idle): new rate takes effect here only.
        phase_d    = 1'b1;
        active_d   = 1'b1;
        shift_d    = shift_s_i;
        load_o     = 1'b1;
        load_val_o = span_m1(shift_s_i);
      end else begin
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      shift_q  <= 2'd3;
    end else begin
      phase_q  <= phase_d;
      active_q <= active_d;
      shift_q  <= shift_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int UNIT_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rate_a_i,
  input  logic rate_b_i,
  input  logic run_i,
  output logic card_clk_o
);

  localparam int MAX_SHIFT = 3;
  localparam int CNT_W     = $clog2(UNIT_CYC << MAX_SHIFT);

  logic [2:0]       raw_in, sync_out;
  logic             run_s;
  rate_shift_t      shift_s;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  assign raw_in = {run_i, rate_a_i, rate_b_i};

  clkdiv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign run_s   = sync_out[2];
  assign shift_s = decode_rate(sync_out[1], sync_out[0]);

  clkdiv_level_timer #(.CNT_W(CNT_W), .RST_SPAN(UNIT_CYC)) timer_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  clkdiv_phase_ctrl #(.UNIT_CYC(UNIT_CYC), .CNT_W(CNT_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .expired_i  (expired),
    .run_s_i    (run_s),
    .shift_s_i  (shift_s),
    .load_o     (load),
    .load_val_o (load_val),
    .phase_o    (card_clk_o)
  );

endmodule

// File: rtl/card_clk_divider_chk.sv
module card_clk_divider_chk #(
  parameter int UNIT_CYC = 8
) (
  input logic clk_i,
  input logic rst_i,
  input logic rate_a_i,
  input logic rate_b_i,
  input logic run_s,
  input logic card_clk
);

  localparam int RUN_W = $clog2(UNIT_CYC * 16) + 1;
  localparam int RUN_MAX = (1 << RUN_W) - 1;

  logic             prev_q;
  logic [RUN_W-1:0] run_len_q;
  logic [RUN_W-1:0] last_high_q;
  logic             changed;

  assign changed = (card_clk != prev_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q      <= 1'b0;
      run_len_q   <= '0;
      last_high_q <= '0;
    end else begin
      prev_q <= card_clk;
      if (changed) begin
        run_len_q <= RUN_W'(1);
        if (prev_q) last_high_q <= run_len_q;
      end else if (run_len_q != RUN_W'(RUN_MAX)) begin
        run_len_q <= run_len_q + 1'b1;
      end
    end
  end

  AST_HIGH_MIN_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (changed && prev_q) |-> (run_len_q >= RUN_W'(UNIT_CYC))); // R4

  AST_LOW_NOT_SHORT: assert property (@(posedge clk_i) disable iff (rst_i)
    (changed && !prev_q) |-> (run_len_q >= last_high_q)); // R4

  AST_HIGH_LEGAL_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
    (changed && prev_q) |-> (run_len_q == RUN_W'(UNIT_CYC)     ||
                             run_len_q == RUN_W'(UNIT_CYC * 2) ||
                             run_len_q == RUN_W'(UNIT_CYC * 4) ||
                             run_len_q == RUN_W'(UNIT_CYC * 8))); // R7

  AST_START_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(card_clk) |-> $past(run_s)); // R5

  AST_SEL_ONE_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({rate_a_i, rate_b_i} ^ $past({rate_a_i, rate_b_i})) <= 1); // R8

  always_comb begin
    if (rst_i) AST_RESET_LOW: assert (card_clk == 1'b0 || prev_q == 1'b0); // R1
  end

endmodule

bind card_clk_divider card_clk_divider_chk #(.UNIT_CYC(UNIT_CYC)) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .rate_a_i (rate_a_i),
  .rate_b_i (rate_b_i),
  .run_s    (run_s),
  .card_clk (card_clk_o)
);

// File: tb/card_clk_divider_tb_top.sv
module card_clk_divider_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 8;
  localparam int SYNC       = 2;
  localparam int WDOG_LIMIT = 200000;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] ratio;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'b00, 8'd8}, '{2'b01, 8'd4}, '{2'b11, 8'd2}, '{2'b10, 8'd1},
    '{2'b00, 8'd8}, '{2'b10, 8'd1}, '{2'b11, 8'd2}, '{2'b01, 8'd4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_a = 1'b0;
  logic rate_b = 1'b0;
  logic run = 1'b1;
  logic card_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int viol   = 0;
  bit done   = 1'b0;

  card_clk_divider #(.UNIT_CYC(UNIT), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .rate_a_i   (rate_a),
    .rate_b_i   (rate_b),
    .run_i      (run),
    .card_clk_o (card_clk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Level-length monitor for R4: highs at least UNIT, lows not shorter than prior high.
  logic mon_prev = 1'b0;
  int   mon_run  = 0;
  int   mon_high = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      mon_prev = 1'b0;
      mon_run  = 0;
      mon_high = 0;
    end else if (card_clk == mon_prev) begin
      mon_run++;
    end else begin
      if (mon_prev && mon_run < UNIT) viol++;
      if (!mon_prev && mon_run < mon_high) viol++;
      if (mon_prev) mon_high = mon_run;
      mon_run  = 1;
      mon_prev = card_clk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts samples while the output holds lvl; ends on the first sample of the next level.
  task automatic level_len(input logic lvl, output int len);
    len = 0;
    while (card_clk == lvl) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    while (card_clk != 1'b0) @(negedge clk);
    while (card_clk != 1'b1) @(negedge clk);
  endtask

  initial begin
    int k;
    int hi;
    int lo;
    int hi2;
    repeat (4) @(negedge clk);
    check(card_clk == 1'b0, "R1 low in reset", int'(card_clk), 0);
    rst = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (card_clk == 1'b0 && k < 100);
    check(k == UNIT, "R1 first rise delay", k, UNIT);
    level_len(1'b1, hi);
    check(hi == 8 * UNIT, "R2 first high at slowest rate", hi, 8 * UNIT);

    // Table walk: each step changes one select bit (R8).
    for (int i = 0; i < 8; i++) begin
      rate_a = VEC[i].sel[1];
      rate_b = VEC[i].sel[0];
      wait_rise();
      wait_rise();
      level_len(1'b1, hi);
      level_len(1'b0, lo);
      check(hi == int'(VEC[i].ratio) * UNIT, "R2 high span", hi, int'(VEC[i].ratio) * UNIT);
      check(lo == int'(VEC[i].ratio) * UNIT, "R2 low span", lo, int'(VEC[i].ratio) * UNIT);
    end

    // R3: change mid-high from slowest to divide-by-4.
    rate_a = 1'b0; rate_b = 1'b0;
    wait_rise();
    wait_rise();
    repeat (5) @(negedge clk);
    rate_b = 1'b1;
    level_len(1'b1, hi);
    level_len(1'b0, lo);
    level_len(1'b1, hi2);
    check(hi == 8 * UNIT - 5, "R3 old high completes", hi, 8 * UNIT - 5);
    check(lo == 8 * UNIT, "R3 old low completes", lo, 8 * UNIT);
    check(hi2 == 4 * UNIT, "R3 new high full width", hi2, 4 * UNIT);

    // R3: change mid-low from divide-by-4 to divide-by-2.
    repeat (3) @(negedge clk);
    rate_a = 1'b1;
    level_len(1'b0, lo);
    level_len(1'b1, hi2);
    check(lo == 4 * UNIT - 3, "R3 low kept during change", lo, 4 * UNIT - 3);
    check(hi2 == 2 * UNIT, "R3 next high new rate", hi2, 2 * UNIT);

    // R5: drop run during a high level at divide-by-2.
    wait_rise();
    repeat (3) @(negedge clk);
    run = 1'b0;
    level_len(1'b1, hi);
    check(hi == 2 * UNIT - 3, "R5 high finishes after stop", hi, 2 * UNIT - 3);
    k = 0;
    repeat (20 * UNIT) begin
      @(negedge clk);
      if (card_clk) k++;
    end
    check(k == 0, "R5 output held low while stopped", k, 0);

    // R6: restart latency and full first high.
    run = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (card_clk == 1'b0 && k < 100);
    check(k == SYNC + 1, "R6 restart latency", k, SYNC + 1);
    level_len(1'b1, hi);
    check(hi == 2 * UNIT, "R6 first high after restart", hi, 2 * UNIT);

    // R7: fastest rate level widths.
    rate_b = 1'b0;
    wait_rise();
    wait_rise();
    level_len(1'b1, hi);
    check(hi == UNIT, "R7 base rate high span", hi, UNIT);

    repeat (4) @(negedge clk);
    check(viol == 0, "R4 level width violations", viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < WDOG_LIMIT) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule